// File: doc/BRIEF.md
# Delayed Read Initiation Gate

This block decides, cycle by cycle, whether a pending delayed memory read may be started on the bus that will carry it. It compares the free space in the read return queue, counted in Dwords, against a required amount. That amount depends on three things: a 2-bit threshold code held in a small configuration register, the kind of read, and the cache line size of the opposite bus.

A requester raises `req_valid` and keeps its command stable. The gate raises `start_permit` for as long as the request is legal and enough space is free. The request is consumed in the cycle in which `start_permit` and the downstream `xfer_ready` are both high, and `req_take` marks that cycle. The bus sequencer, the read data storage and the prefetch length lie outside the gate.

Top module: `rdgate_initiate`

## Requirements
- R1: After reset the threshold code is 00, so with no configuration write a read needs only 8 free Dwords, whatever the line size.
- R2: With code 00, each of the three read commands is permitted exactly when at least 8 Dwords are free.
- R3: Code 01 is not a legal setting and behaves exactly like code 00.
- R4: With code 10, Memory Read Line and Memory Read Multiple need one full cache line free, while plain Memory Read needs 8 Dwords.
- R5: With code 11, all three read commands need one full cache line free.
- R6: The cache line size is taken from `cls_other`, the size of the opposite bus, in Dwords. The values 8, 16 and 32 are used as given. Any other value, 0 included, counts as 8.
- R7: The command encoding is 2'b00 Memory Read, 2'b01 Memory Read Line and 2'b10 Memory Read Multiple. The encoding 2'b11 never yields a permit.
- R8: `start_permit` is low whenever `req_valid` is low, and it does not depend on `xfer_ready`. `req_take` is high exactly when `start_permit` and `xfer_ready` are both high.
- R9: A write with `cfg_we` high loads `cfg_code` at the clock edge. The new code governs the permit from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load strobe for the threshold code |
| cfg_code | input | 2 | Threshold code to load |
| cls_other | input | 8 | Cache line size of the opposite bus, in Dwords |
| req_valid | input | 1 | A delayed read is pending |
| req_cmd | input | 2 | Read command of the pending request |
| free_dw | input | 8 | Free space in the read return queue, in Dwords |
| xfer_ready | input | 1 | Sequencer is able to start the read this cycle |
| start_permit | output | 1 | Pending read may be started |
| req_take | output | 1 | Request consumed this cycle |

## Verification
A configuration write and a threshold decision can fall in the same cycle. In that cycle the old code must still govern the permit, and the new code must take over one cycle later. The bench provokes this by writing code 11 while a Memory Read Line with 8 to 15 Dwords free is pending under a line size of 16. It judges the permit before and after the clock edge. Random runs also mix writes with pending requests and compare every cycle against a bench model that updates the code one edge late.

// File: rtl/rdgate_pkg.sv
// Shared types for the delayed read initiation gate.
package rdgate_pkg;
    typedef enum logic [1:0] {
        CMD_MR  = 2'b00,
        CMD_MRL = 2'b01,
        CMD_MRM = 2'b10,
        CMD_BAD = 2'b11
    } rd_cmd_e;

    typedef enum logic [1:0] {
        THR_FLOOR   = 2'b00,
        THR_ALIAS   = 2'b01,
        THR_SPLIT   = 2'b10,
        THR_FULLINE = 2'b11
    } thr_code_e;
endpackage

// File: rtl/rdgate_cfg_reg.sv
// Threshold code register.
// Holds the 2-bit threshold code. It resets to the floor code and loads on a write strobe.
// Assumes: synchronous active-low reset.
module rdgate_cfg_reg
    import rdgate_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  logic [1:0] wr_code,
    output thr_code_e code_q
);
    // Load or reset the stored code.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code_q <= THR_FLOOR;
        else if (wr_en)
            code_q <= thr_code_e'(wr_code);
    end
endmodule

// File: rtl/rdgate_line_norm.sv
// Cache line size normaliser.
// Passes supported line sizes through and maps every other value to the fallback size.
// Assumes: the line size is given in Dwords.
module rdgate_line_norm #(
    parameter int CLS_W   = 8,
    parameter int NEED_W  = 8,
    parameter int NSIZES  = 3,
    parameter int BASE_DW = 8
) (
    input  logic [CLS_W-1:0]  cls_in,
    output logic [NEED_W-1:0] line_dw
);
    localparam int MAX_DW = BASE_DW << (NSIZES - 1);

    logic [NSIZES-1:0] hit;

    // One comparator per supported size: BASE_DW, 2*BASE_DW, ...
    for (genvar g = 0; g < NSIZES; g++) begin : g_size
        assign hit[g] = (cls_in == CLS_W'(BASE_DW << g));
    end

    // Choose the matched size, or fall back to BASE_DW.
    always_comb begin
        line_dw = NEED_W'(BASE_DW);
        for (int i = 0; i < NSIZES; i++)
            if (hit[i])
                line_dw = NEED_W'(BASE_DW << i);
    end

    initial begin
        if (MAX_DW >= (1 << NEED_W))
            $error("rdgate_line_norm: NEED_W too small for largest line");
    end
endmodule

// File: rtl/rdgate_need_calc.sv
// Required free space calculator.
// Picks the number of free Dwords a read needs from the threshold code and the command.
// Assumes: line_dw is already normalised.
module rdgate_need_calc
    import rdgate_pkg::*;
#(
    parameter int NEED_W  = 8,
    parameter int BASE_DW = 8
) (
    input  thr_code_e         code,
    input  rd_cmd_e           cmd,
    input  logic [NEED_W-1:0] line_dw,
    output logic [NEED_W-1:0] need_dw,
    output logic              cmd_ok
);
    // Choose between the fixed floor and a full line.
    always_comb begin
        cmd_ok = (cmd != CMD_BAD);
        unique case (code)
            THR_FULLINE: need_dw = line_dw;
            THR_SPLIT:   need_dw = (cmd == CMD_MR) ? NEED_W'(BASE_DW) : line_dw;
            default:     need_dw = NEED_W'(BASE_DW);
        endcase
    end
endmodule

// File: rtl/rdgate_initiate.sv
// Delayed read initiation gate (top).
// Raises start_permit while a legal pending read has enough free queue space.
// A request is consumed when the permit and xfer_ready meet in one cycle.
// Assumes: the requester keeps req_cmd stable while req_valid is high and the request is not yet taken.
module rdgate_initiate
    import rdgate_pkg::*;
#(
    parameter int FREE_W  = 8,
    parameter int CLS_W   = 8,
    parameter int BASE_DW = 8,
    parameter int NSIZES  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_code,
    input  logic [CLS_W-1:0]  cls_other,
    input  logic              req_valid,
    input  logic [1:0]        req_cmd,
    input  logic [FREE_W-1:0] free_dw,
    input  logic              xfer_ready,
    output logic              start_permit,
    output logic              req_take
);
    localparam int NEED_W = FREE_W;

    thr_code_e         code_q;
    logic [NEED_W-1:0] line_dw;
    logic [NEED_W-1:0] need_dw;
    logic              cmd_ok;

    rdgate_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_code (cfg_code),
        .code_q  (code_q)
    );

    rdgate_line_norm #(
        .CLS_W   (CLS_W),
        .NEED_W  (NEED_W),
        .NSIZES  (NSIZES),
        .BASE_DW (BASE_DW)
    ) u_norm (
        .cls_in  (cls_other),
        .line_dw (line_dw)
    );

    rdgate_need_calc #(
        .NEED_W  (NEED_W),
        .BASE_DW (BASE_DW)
    ) u_need (
        .code    (code_q),
        .cmd     (rd_cmd_e'(req_cmd)),
        .line_dw (line_dw),
        .need_dw (need_dw),
        .cmd_ok  (cmd_ok)
    );

    // Permit: a pending legal request with enough free space.
    always_comb begin
        start_permit = req_valid && cmd_ok && (free_dw >= need_dw);
        req_take     = start_permit && xfer_ready;
    end
endmodule

// File: rtl/rdgate_checker.sv
// Assertion checker for rdgate_initiate, attached with bind.
module rdgate_checker #(
    parameter int FREE_W = 8,
    parameter int CLS_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [1:0]        cfg_code,
    input logic [CLS_W-1:0]  cls_other,
    input logic              req_valid,
    input logic [1:0]        req_cmd,
    input logic [FREE_W-1:0] free_dw,
    input logic              xfer_ready,
    input logic              start_permit,
    input logic              req_take
);
    logic [FREE_W-1:0] chk_line;
    logic              was_run;

    // Line size as the requirement states it.
    always_comb begin
        if (cls_other == 8 || cls_other == 16 || cls_other == 32)
            chk_line = FREE_W'(cls_other);
        else
            chk_line = FREE_W'(8);
    end

    // Marks the cycles that have a preceding out-of-reset cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) was_run <= 1'b0;
        else        was_run <= 1'b1;
    end

    AST_BAD_CMD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_cmd == 2'b11) |-> !start_permit); // R7
    AST_NO_VALID_NO_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !start_permit); // R8
    AST_FLOOR_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
        start_permit |-> (free_dw >= FREE_W'(8))); // R2
    AST_TAKE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        req_take |-> (start_permit && xfer_ready)); // R8
    AST_FULLINE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (was_run && $past(cfg_we && cfg_code == 2'b11) && (free_dw < chk_line))
        |-> !start_permit); // R9
endmodule

bind rdgate_initiate rdgate_checker #(.FREE_W(FREE_W), .CLS_W(CLS_W)) u_chk (.*);

// File: tb/rdgate_initiate_test.sv
module rdgate_initiate_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_we;
    logic [1:0] cfg_code;
    logic [7:0] cls_other;
    logic       req_valid;
    logic [1:0] req_cmd;
    logic [7:0] free_dw;
    logic       xfer_ready;
    logic       start_permit;
    logic       req_take;

    int checks = 0;
    int errors = 0;
    logic [1:0] model_code;
    bit done = 0;

    always #10 clk = ~clk;

    rdgate_initiate uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_code(cfg_code),
        .cls_other(cls_other), .req_valid(req_valid), .req_cmd(req_cmd),
        .free_dw(free_dw), .xfer_ready(xfer_ready),
        .start_permit(start_permit), .req_take(req_take)
    );

    function automatic int line_of(input logic [7:0] c);
        return (c == 8 || c == 16 || c == 32) ? int'(c) : 8;
    endfunction

    function automatic logic exp_permit(input logic [1:0] code, input logic [7:0] c,
                                        input logic v, input logic [1:0] cmd,
                                        input logic [7:0] f);
        int need;
        if (!v || cmd == 2'b11) return 1'b0;
        if (code == 2'b11 || (code == 2'b10 && cmd != 2'b00)) need = line_of(c);
        else need = 8;
        return int'(f) >= need;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b (code=%0d cls=%0d v=%0b cmd=%0d free=%0d rdy=%0b)",
                     req, act, exp, model_code, cls_other, req_valid, req_cmd, free_dw, xfer_ready);
        end
    endtask

    // Apply a request at the negedge, then check both outputs before the next posedge.
    task automatic apply(input string req, input logic [7:0] c, input logic v,
                         input logic [1:0] cmd, input logic [7:0] f, input logic r);
        logic e;
        @(negedge clk);
        cls_other = c; req_valid = v; req_cmd = cmd; free_dw = f; xfer_ready = r;
        #2;
        e = exp_permit(model_code, c, v, cmd, f);
        check(req, start_permit, e);
        check(req, req_take, e && r);
    endtask

    task automatic write_code(input logic [1:0] code);
        @(negedge clk);
        cfg_we = 1'b1; cfg_code = code;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        model_code = code;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_code = 2'b00; cls_other = 8'd32;
        req_valid = 1'b0; req_cmd = 2'b00; free_dw = 8'd0; xfer_ready = 1'b0;
        model_code = 2'b00;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset code is 00, so a line of 32 is not required
        apply("R1", 8'd32, 1'b1, 2'b01, 8'd8, 1'b1);
        apply("R1", 8'd32, 1'b1, 2'b10, 8'd7, 1'b1);

        // R2: floor of 8 for each command
        for (int cmd = 0; cmd < 3; cmd++) begin
            apply("R2", 8'd16, 1'b1, 2'(cmd), 8'd7, 1'b1);
            apply("R2", 8'd16, 1'b1, 2'(cmd), 8'd8, 1'b1);
        end

        // R3: code 01 matches code 00
        write_code(2'b01);
        apply("R3", 8'd32, 1'b1, 2'b10, 8'd8, 1'b1);
        apply("R3", 8'd32, 1'b1, 2'b00, 8'd7, 1'b0);

        // R4: split thresholds
        write_code(2'b10);
        apply("R4", 8'd16, 1'b1, 2'b00, 8'd8, 1'b1);
        apply("R4", 8'd16, 1'b1, 2'b01, 8'd15, 1'b1);
        apply("R4", 8'd16, 1'b1, 2'b10, 8'd16, 1'b1);

        // R5: full line for all commands
        write_code(2'b11);
        apply("R5", 8'd32, 1'b1, 2'b00, 8'd31, 1'b1);
        apply("R5", 8'd32, 1'b1, 2'b00, 8'd32, 1'b1);
        apply("R5", 8'd16, 1'b1, 2'b01, 8'd16, 1'b1);

        // R6: unsupported sizes count as 8
        apply("R6", 8'd0, 1'b1, 2'b01, 8'd8, 1'b1);
        apply("R6", 8'd12, 1'b1, 2'b10, 8'd8, 1'b1);
        apply("R6", 8'd4, 1'b1, 2'b10, 8'd7, 1'b1);

        // R7: encoding 11 never permits
        apply("R7", 8'd8, 1'b1, 2'b11, 8'd255, 1'b1);

        // R8: no valid, and ready has no effect on the permit
        apply("R8", 8'd8, 1'b0, 2'b00, 8'd255, 1'b1);
        apply("R8", 8'd8, 1'b1, 2'b00, 8'd200, 1'b0);
        apply("R8", 8'd8, 1'b1, 2'b00, 8'd200, 1'b1);

        // R9: write lands while a request is pending
        write_code(2'b00);
        @(negedge clk);
        cls_other = 8'd16; req_valid = 1'b1; req_cmd = 2'b01; free_dw = 8'd10; xfer_ready = 1'b0;
        cfg_we = 1'b1; cfg_code = 2'b11;
        #2 check("R9", start_permit, 1'b1);
        @(posedge clk); #1 cfg_we = 1'b0; model_code = 2'b11;
        @(negedge clk); #2 check("R9", start_permit, 1'b0);

        // Random mix of writes and requests
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] c;
            logic [7:0] pick;
            if ($urandom_range(0, 9) == 0) write_code(2'($urandom_range(0, 3)));
            pick = 8'($urandom_range(0, 5));
            case (pick)
                0: c = 8'd8; 1: c = 8'd16; 2: c = 8'd32; 3: c = 8'd0;
                default: c = 8'($urandom_range(0, 255));
            endcase
            apply("R2-R8 random", c, 1'($urandom_range(0, 7) != 0), 2'($urandom_range(0, 3)),
                  8'($urandom_range(0, 40)), 1'($urandom_range(0, 1)));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule